// File: doc/BRIEF.md
# Phase-Aligning Oscillatory Neuron

This block is one neuron of a digital oscillator network. It drives a 1-bit square wave with a period of sixteen slow ticks. A 4-bit phase register selects the output, one of sixteen evenly spaced delays of a rotating pattern that is half ones and half zeros. A neighbouring network supplies a 1-bit input oscillation of the same shape. The neuron finds the rising edges of both waves on slow ticks and counts the ticks between them. It then moves its phase by that signed lag so that its output lines up with the input.

The slow tick is a one-cycle enable that arrives on the system clock. The phase register and the pattern rotation therefore share one clock domain but advance at different rates. A serial port loads the phase register MSB first while a strobe is held. The same port shifts out the old value, so several neurons can be chained to set initial states and to read final states. Each applied correction raises a one-cycle flag.

Top module: `osc_neuron`

## Requirements
- R1: Reset sets the phase to 0 and clears the update flag and the scan output. The rotating pattern is restored, so the output is 1 before the first tick.
- R2: In slow period n (n ticks after reset), `wave_out` is 1 exactly when (phase + n) mod 16 is below 8. One phase step is 1/16 of the period, and a larger phase leads in time.
- R3: Rising edges of both waves are taken at ticks. When the output edge comes first and the input edge follows L ticks later (1 to 8), the phase drops by L. When the input edge comes first and the output edge follows L ticks later, the phase rises by L. Both are modulo 16, so the phase ends equal to the input's phase.
- R4: A measurement is dropped if the second edge has not come within 8 ticks of the first. With no input edges the phase is held indefinitely.
- R5: A correction is applied on the tick of the second edge and `phase_upd` is high for exactly that one cycle. Edges on the same tick cause no correction.
- R6: While `load_en` is high, every system clock shifts the phase left with `scan_in` entering bit 0. `scan_out` always shows bit 3, so four clocks load a value MSB first and unload the old one in the same order.
- R7: While `load_en` is high no correction is applied and `phase_upd` stays low.
- R8: Once the phase equals the input's phase, `wave_out` matches `wave_in` in every period and no further correction occurs.
- R9: `wave_out` changes only after a tick or a serial shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow-tick enable, one cycle wide |
| wave_in | input | 1 | Input oscillation, changes only on slow periods |
| load_en | input | 1 | Serial load/scan strobe |
| scan_in | input | 1 | Serial data from the previous neuron |
| wave_out | output | 1 | Output oscillation |
| scan_out | output | 1 | Serial data to the next neuron (phase MSB) |
| phase | output | 4 | Current phase register |
| phase_upd | output | 1 | One-cycle pulse on each correction |

## Verification
The properties assume that `tick` is a single-cycle pulse and that `wave_in` changes only in the cycle right after a tick. Both waves are treated as sampled square signals of sixteen ticks. The bench drives the input from its own tick count as a clean half-high wave of a chosen phase. It switches the input on only at a true rising edge, and only after the output has run long enough that any measurement left over from a serial load has expired. Each correction therefore comes from genuine edges and gives a phase the bench can predict.

// File: rtl/osc_neuron.sv
module osc_neuron #(
  parameter int STAGES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         wave_in,
  input  logic                         load_en,
  input  logic                         scan_in,
  output logic                         wave_out,
  output logic                         scan_out,
  output logic [$clog2(STAGES)-1:0]    phase,
  output logic                         phase_upd
);
  localparam int PW   = $clog2(STAGES);
  localparam int HALF = STAGES / 2;
  localparam logic [STAGES-1:0] RING_INIT = {{HALF{1'b0}}, {HALF{1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_WAIT_OUT, S_WAIT_IN} st_t;

  logic [STAGES-1:0] ring;
  logic [PW-1:0]     lag;
  logic              in_d, out_d;
  st_t               st;

  assign wave_out = ring[phase];
  assign scan_out = phase[PW-1];

  wire in_rise  = tick & wave_in  & ~in_d;
  wire out_rise = tick & wave_out & ~out_d;
  wire window_end = (lag == PW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n)    ring <= RING_INIT;
    else if (tick) ring <= {ring[0], ring[STAGES-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      lag       <= '0;
      in_d      <= 1'b0;
      out_d     <= 1'b0;
      st        <= S_IDLE;
      phase_upd <= 1'b0;
    end else begin
      phase_upd <= 1'b0;
      if (tick) begin
        in_d  <= wave_in;
        out_d <= wave_out;
      end
      if (load_en) begin
        phase <= {phase[PW-2:0], scan_in};
        st    <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (in_rise && !out_rise) begin
              st  <= S_WAIT_OUT;
              lag <= PW'(1);
            end else if (out_rise && !in_rise) begin
              st  <= S_WAIT_IN;
              lag <= PW'(1);
            end
          end
          S_WAIT_OUT: begin
            if (out_rise) begin
              phase     <= phase + lag;
              phase_upd <= 1'b1;
              out_d     <= wave_in;
              st        <= S_IDLE;
            end else if (tick) begin
              if (window_end) st <= S_IDLE;
              else            lag <= lag + PW'(1);
            end
          end
          S_WAIT_IN: begin
            if (in_rise) begin
              phase     <= phase - lag;
              phase_upd <= 1'b1;
              out_d     <= wave_in;
              st        <= S_IDLE;
            end else if (tick) begin
              if (window_end) st <= S_IDLE;
              else            lag <= lag + PW'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/osc_neuron_sva.sv
module osc_neuron_sva #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          load_en,
  input logic          scan_in,
  input logic          wave_out,
  input logic [PW-1:0] phase,
  input logic          phase_upd
);
  p_upd_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |-> $past(tick));

  p_upd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |=> !phase_upd);

  p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(phase) || phase_upd));

  p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (phase == {$past(phase[PW-2:0]), $past(scan_in)}));

  p_no_upd_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !phase_upd);

  p_wave_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_out) |-> ($past(tick) || $past(load_en)));
endmodule

bind osc_neuron osc_neuron_sva #(.PW(PW)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en), .scan_in(scan_in),
  .wave_out(wave_out), .phase(phase), .phase_upd(phase_upd)
);

// File: tb/osc_neuron_bench.sv
module osc_neuron_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wave_in = 1'b0;
  logic load_en = 1'b0, scan_in = 1'b0;
  logic wave_out, scan_out, phase_upd;
  logic [3:0] phase;

  osc_neuron u_osc_neuron (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wave_in(wave_in),
    .load_en(load_en), .scan_in(scan_in), .wave_out(wave_out),
    .scan_out(scan_out), .phase(phase), .phase_upd(phase_upd)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int n_tk = 0, q = 0, tc = 0;
  bit arm = 0, in_en = 0;
  logic [3:0] exp_q[$];

  function automatic logic sq(int p, int k);
    return ((p + k) % 16) < 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slow tick and input wave generator
  initial forever begin
    @(negedge clk);
    if (tick && rst_n) n_tk++;
    if (arm && !in_en && ((q + n_tk) % 16 == 0)) in_en = 1;
    wave_in = in_en ? sq(q, n_tk) : 1'b0;
    tc = (tc + 1) % 4;
    tick = (tc == 3);
  end

  // scoreboard monitor
  initial forever begin
    logic [3:0] e;
    @(negedge clk); #1;
    if (rst_n && phase_upd) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected correction", int'(phase), -1);
      else begin
        e = exp_q.pop_front();
        chk(phase == e, "R3 corrected phase", int'(phase), int'(e));
      end
    end
  end

  task automatic do_reset(int qv, bit av);
    @(negedge clk); #2;
    rst_n = 0; arm = 0; in_en = 0; q = qv;
    repeat (3) @(negedge clk);
    #2;
    n_tk = 0; arm = av;
    in_en = av && (qv % 16 == 0);
    wave_in = in_en ? sq(qv, 0) : 1'b0;
    rst_n = 1;
  endtask

  task automatic wait_ticks(int k);
    repeat (k * 4) @(negedge clk);
  endtask

  task automatic wave_check(int ph, string req);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); #1;
      chk(wave_out == sq(ph, n_tk), req, int'(wave_out), int'(sq(ph, n_tk)));
    end
  endtask

  task automatic serial_load(logic [3:0] v);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      load_en = 1; scan_in = v[3-i];
      if (i > 0) chk(phase_upd == 1'b0, "R7 flag during load", int'(phase_upd), 0);
    end
    @(negedge clk); #2;
    load_en = 0;
  endtask

  task automatic serial_read(output logic [3:0] rd);
    logic b;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      b = scan_out; rd[3-i] = b;
      load_en = 1; scan_in = b;
      if (i > 0) chk(phase_upd == 1'b0, "R7 flag during scan", int'(phase_upd), 0);
    end
    @(negedge clk); #2;
    load_en = 0;
  endtask

  task automatic converge(int qv, int start);
    if (qv != start) exp_q.push_back(qv[3:0]);
    do_reset(qv, 1);
    wait_ticks(60);
    chk(phase == qv[3:0], "R3 final phase", int'(phase), qv);
    chk(exp_q.size() == 0, "R3 correction count", exp_q.size(), 0);
    wave_check(qv, "R8 aligned output");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [3:0] rd;
    do_reset(0, 0);
    chk(phase == 4'd0, "R1 phase", int'(phase), 0);
    chk(phase_upd == 1'b0, "R1 flag", int'(phase_upd), 0);
    chk(scan_out == 1'b0, "R1 scan_out", int'(scan_out), 0);
    chk(wave_out == 1'b1, "R1 wave_out", int'(wave_out), 1);
    wave_check(0, "R2 waveform phase 0");
    wait_ticks(40);
    chk(phase == 4'd0, "R4 held without input", int'(phase), 0);

    converge(0, 0);   // R5 coincident edges, no correction
    converge(12, 0);  // R3 output first, lag 4
    converge(3, 0);   // R4 window expires, then R3 input first, lag 3
    converge(8, 0);   // R3 output first, lag 8 (window limit)

    do_reset(0, 0);
    serial_load(4'b1010);
    chk(phase == 4'd10, "R6 loaded phase", int'(phase), 10);
    wait_ticks(40);
    chk(phase == 4'd10, "R4 held after load", int'(phase), 10);
    wave_check(10, "R9 waveform phase 10");
    exp_q.push_back(4'd4);
    @(negedge clk); #2;
    q = 4; arm = 1;
    wait_ticks(60);
    chk(phase == 4'd4, "R3 phase after load", int'(phase), 4);
    serial_read(rd);
    chk(rd == 4'd4, "R6 scan readback", int'(rd), 4);
    chk(phase == 4'd4, "R6 recirculated phase", int'(phase), 4);
    wait_ticks(40);
    chk(exp_q.size() == 0, "R5 correction count", exp_q.size(), 0);
    wave_check(4, "R8 aligned after scan");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule